// File: doc/BRIEF.md
# Indirect Configuration Register Port

This block is a slave on a simple synchronous register bus that exposes a small internal configuration space through only two register numbers. One register number holds an address pointer that software writes first; the other is a data window whose read value is selected by whatever the pointer currently holds. The internal space is a fixed table of clock-divider and strap constants, so the window can be read but never changed.

Every bus access is a single-cycle strobe. Read data comes from a register and appears on the clock after the read strobe. At all other times it is zero, so several such slaves can share an OR-combined read bus. Register numbers other than the two decoded ones read as zero and ignore writes. The asynchronous active-low reset is released synchronously inside the block.

Top module: `indirect_cfg_port`

## Requirements
- R1: A write to the pointer register (register number 0x0C by default, set by a parameter) stores the full 32-bit write data, and a later read of that register number returns the stored value unchanged.
- R2: A read of the data window (register number 0x0D by default, set by a parameter) while the pointer equals 0x0000_0060 returns 0xB501_0900, that is 0xB5 in bits 31:24, 1 in bits 23:16 and 9 in bits 15:8.
- R3: A data-window read returns 0x0500_0000 when the pointer equals 0x80, and 0x0200_0000 when the pointer equals 0xC0.
- R4: A data-window read returns 0x0100_0000 when the pointer equals 0xE0, and also when it equals 0x100.
- R5: A data-window read with any other pointer value returns zero. All 32 pointer bits take part in the match, so 0x1000_0060 reads zero.
- R6: A write to the data window changes neither the pointer nor any later read value.
- R7: Reset clears the pointer to zero. A window read after reset therefore returns zero.
- R8: A read of any register number other than the pointer and the window returns zero. A write to such a register number leaves the pointer unchanged.
- R9: Read data is registered. It is valid on the clock after the read strobe and is zero on every clock that follows a cycle without a read strobe.
- R10: The read data output is zero while reset is held, even when the read strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_num | input | RNUM_W (10) | Register number of the current access |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wr_data | input | DATA_W (32) | Write data |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_data | output | DATA_W (32) | Registered read data, valid one clock after rd_stb and zero otherwise |

## Verification
The bench uses the default parameters: a 10-bit register number with the pointer at 0x0C and the window at 0x0D. A 10-bit number space is small enough to sweep every register number for reads and writes, which covers all of the undecoded space named in R8. The pointer is also swept over every value from 0 to 0x1FF, which reaches all five table entries and each of their neighbours. A few values with high bits set check that all 32 bits take part in the match.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int unsigned CFG_W = 32;

  // Internal addresses of the constant table
  localparam logic [CFG_W-1:0] IA_PLL   = 32'h0000_0060;
  localparam logic [CFG_W-1:0] IA_BUSD  = 32'h0000_0080;
  localparam logic [CFG_W-1:0] IA_OPBD  = 32'h0000_00C0;
  localparam logic [CFG_W-1:0] IA_PERD  = 32'h0000_00E0;
  localparam logic [CFG_W-1:0] IA_AHBD  = 32'h0000_0100;

  // Constant contents
  localparam logic [CFG_W-1:0] CV_PLL   = {8'hB5, 8'h01, 8'h09, 8'h00};
  localparam logic [CFG_W-1:0] CV_BUSD  = {8'h05, 24'h0};
  localparam logic [CFG_W-1:0] CV_OPBD  = {8'h02, 24'h0};
  localparam logic [CFG_W-1:0] CV_UNITY = {8'h01, 24'h0};

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_ptr_reg.sv
module cfg_ptr_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr
);
  logic [DATA_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (we) ptr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr == $past(wdata)); // R1
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ptr)); // R6
endmodule

// File: rtl/cfg_const_table.sv
module cfg_const_table
  import cfgport_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] value
);
  logic [CFG_W-1:0] addr_w;
  logic [CFG_W-1:0] val_w;

  generate
    if (DATA_W >= CFG_W) begin : g_wide
      assign addr_w = addr[CFG_W-1:0];
      if (DATA_W > CFG_W) begin : g_pad
        logic hi_zero;
        assign hi_zero = (addr[DATA_W-1:CFG_W] == '0);
        assign value = hi_zero ? {{(DATA_W-CFG_W){1'b0}}, val_w} : '0;
      end else begin : g_eq
        assign value = val_w;
      end
    end else begin : g_narrow
      assign addr_w = {{(CFG_W-DATA_W){1'b0}}, addr};
      assign value  = val_w[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (addr_w)
      IA_PLL:           val_w = CV_PLL;
      IA_BUSD:          val_w = CV_BUSD;
      IA_OPBD:          val_w = CV_OPBD;
      IA_PERD, IA_AHBD: val_w = CV_UNITY;
      default:          val_w = '0;
    endcase
  end
endmodule

// File: rtl/indirect_cfg_port.sv
module indirect_cfg_port
  import cfgport_pkg::*;
#(
  parameter int unsigned RNUM_W   = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PTR_NUM  = 'h00C,
  parameter int unsigned WIN_NUM  = 'h00D,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RNUM_W-1:0] reg_num,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [RNUM_W-1:0] PTR_SEL = RNUM_W'(PTR_NUM);
  localparam logic [RNUM_W-1:0] WIN_SEL = RNUM_W'(WIN_NUM);

  logic              rst_s_n;
  logic              hit_ptr, hit_win;
  logic              ptr_we;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] tbl_val;
  logic [DATA_W-1:0] rd_d, rd_q;

  cfg_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign hit_ptr = (reg_num == PTR_SEL);
  assign hit_win = (reg_num == WIN_SEL);
  assign ptr_we  = wr_stb & hit_ptr;

  cfg_ptr_reg #(.DATA_W(DATA_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (ptr_we),
    .wdata (wr_data),
    .ptr   (ptr_q)
  );

  cfg_const_table #(.DATA_W(DATA_W)) u_tbl (
    .addr  (ptr_q),
    .value (tbl_val)
  );

  always_comb begin
    rd_d = '0;
    if (rd_stb) begin
      if (hit_ptr)      rd_d = ptr_q;
      else if (hit_win) rd_d = tbl_val;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rd_q <= '0;
    else          rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_stb |=> rd_data == '0); // R9
  AST_PTR_READ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb && hit_ptr) |=> rd_data == $past(ptr_q)); // R1
  AST_PLL_WORD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb && hit_win && ptr_q == DATA_W'(IA_PLL)) |=> rd_data == DATA_W'(CV_PLL)); // R2
  AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb && !hit_ptr && !hit_win) |=> rd_data == '0); // R8
  AST_WIN_WR_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_stb && hit_win) |=> $stable(ptr_q)); // R6
endmodule

// File: tb/indirect_cfg_port_test.sv
module indirect_cfg_port_test;
  localparam int RW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [RW-1:0] reg_num;
  logic          wr_stb;
  logic [DW-1:0] wr_data;
  logic          rd_stb;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  indirect_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  function automatic logic [31:0] exp_win(input logic [31:0] p);
    case (p)
      32'h60:         return (32'hB5 << 24) | (32'h1 << 16) | (32'h9 << 8);
      32'h80:         return 32'h5 << 24;
      32'hC0:         return 32'h2 << 24;
      32'hE0, 32'h100: return 32'h1 << 24;
      default:        return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [RW-1:0] n, input logic [31:0] d);
    @(negedge clk);
    reg_num = n; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic do_rd(input logic [RW-1:0] n, output logic [31:0] v);
    @(negedge clk);
    reg_num = n; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_num = '0; wr_stb = 0; wr_data = '0; rd_stb = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 read during reset", rd_data, 32'h0);
    rd_stb = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset state of pointer and window
    do_rd(10'h00C, v); check("R7 pointer after reset", v, 32'h0);
    do_rd(10'h00D, v); check("R7 window after reset", v, 32'h0);

    // R1: pointer store/readback patterns
    do_wr(10'h00C, 32'hDEAD_BEEF); do_rd(10'h00C, v); check("R1 ptr DEADBEEF", v, 32'hDEAD_BEEF);
    do_wr(10'h00C, 32'hFFFF_FFFF); do_rd(10'h00C, v); check("R1 ptr all ones", v, 32'hFFFF_FFFF);
    do_wr(10'h00C, 32'h0000_0001); do_rd(10'h00C, v); check("R1 ptr one", v, 32'h1);

    // R2 R3 R4 R5: sweep pointer over 0..0x1FF
    for (int p = 0; p < 512; p++) begin
      do_wr(10'h00C, 32'(p));
      do_rd(10'h00D, v);
      if (p == 'h60)                    check("R2 window", v, exp_win(32'(p)));
      else if (p == 'h80 || p == 'hC0)  check("R3 window", v, exp_win(32'(p)));
      else if (p == 'hE0 || p == 'h100) check("R4 window", v, exp_win(32'(p)));
      else                              check("R5 window", v, 32'h0);
    end
    do_wr(10'h00C, 32'h1000_0060); do_rd(10'h00D, v); check("R5 high bit set", v, 32'h0);
    do_wr(10'h00C, 32'h8000_0100); do_rd(10'h00D, v); check("R5 msb set", v, 32'h0);

    // R6: window writes ignored
    do_wr(10'h00C, 32'h80);
    do_wr(10'h00D, 32'h0000_0060);
    do_rd(10'h00C, v); check("R6 pointer after window write", v, 32'h80);
    do_rd(10'h00D, v); check("R6 window after window write", v, 32'h0500_0000);

    // R9: read data zero on cycle after no strobe
    do_wr(10'h00C, 32'h60);
    do_rd(10'h00D, v); check("R9 valid after strobe", v, 32'hB501_0900);
    @(negedge clk); check("R9 zero when idle", rd_data, 32'h0);

    // R8: sweep every register number
    do_wr(10'h00C, 32'h60);
    for (int n = 0; n < 1024; n++) begin
      if (n != 'h0C && n != 'h0D) begin
        do_wr(10'(n), 32'h0000_00C0);
        do_rd(10'(n), v);
        check("R8 undecoded read", v, 32'h0);
      end
    end
    do_rd(10'h00C, v); check("R8 pointer after undecoded writes", v, 32'h60);

    // R7: reset mid-run
    do_wr(10'h00C, 32'hE0);
    do_reset();
    do_rd(10'h00C, v); check("R7 pointer cleared", v, 32'h0);
    do_rd(10'h00D, v); check("R7 window after reset", v, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule